// File: doc/BRIEF.md
# Microcoded ALU Operand and Function Unit

This block is the arithmetic stage of a 16-bit microcoded datapath. Each cycle it takes a left operand straight from the register bus and picks a right operand from one of three places: the memory data register, a small constant generator, or a fault-code input. Fields of the current microword then control the computation. They choose the function (either named directly or handed over to three opcode bits), the width (full word or low byte), where the carry-in comes from, whether the status flags are captured, and whether the result is shifted right by one before it reaches the output bus.

The constant generator has only four values: 0, +1, -2 and -1. Microcode therefore builds its common idioms from those:

- increment is ADD with +1
- decrement is ADD with -1
- step by two is SUB of -2
- pass-through is AND with -1

The result bus is combinational. The only state is the four-bit status flag register. It feeds the carry-in and is loaded on a clock edge when the microword asks for it.

Top module: `mcalu_unit`

## Requirements
- R1: Right-operand select `rsel_i` encodes 0 = memory data register, 1 = constant generator, 2 = fault-code input, 3 = zero.
- R2: The constant field `imm_i` encodes 0 = 0, 1 = +1, 2 = -2, 3 = -1, each extended to the full word.
- R3: `op_i` encodes 1 = AND, 2 = SUB (L + ~R + 1), 3 = ADD (L + R). With these codes `ir_fn_i` has no effect and `wb_o` is 1.
- R4: `op_i` = 0 takes the function from `ir_fn_i`: 0 SUB, 1 ADD, 2 compare (SUB with `wb_o` = 0), 3 OR, 4 AND, 5 XOR, 6 add-with-carry, 7 subtract-with-carry. `wb_o` is 1 for every other case.
- R5: With `byte_i` = 1, the operation uses bits [7:0] only. The result bus carries that byte with bit 7 replicated into bits [15:8].
- R6: With `cin_en_i` = 0, ADD uses carry-in 0 and SUB/compare uses carry-in 1. With `cin_en_i` = 1, both use the stored C flag. Add-with-carry and subtract-with-carry always use the stored C flag.
- R7: When `set_flags_i` = 1, `flags_o` = {Z,N,V,C} (bit 3 to bit 0) loads at the next rising edge from the unshifted result at the selected width. The flags are set as follows:
  - Z: the result is zero.
  - N: the top bit of the result.
  - C: the carry out of the adder (for SUB, 1 means no borrow).
  - V: signed overflow.
  - Logic functions clear C and V.
- R8: `flags_o` is 0 after reset and holds its value on every edge where `set_flags_i` = 0.
- R9: With `rshift_i` = 1, `zbus_o` is the (sign-extended) result shifted right by one, with a 0 entering bit 15.
- R10: The idioms below give these results on a 16-bit word:
  - ADD +1 gives L+1.
  - ADD -1 gives L-1.
  - SUB -2 gives L+2.
  - AND -1 gives L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lbus_i | input | 16 | Left operand from the register bus |
| mdr_i | input | 16 | Memory data register value |
| fault_i | input | 16 | Fault code / encoder value |
| rsel_i | input | 2 | Right-operand select |
| imm_i | input | 2 | Constant generator code |
| op_i | input | 2 | Function field of the microword |
| ir_fn_i | input | 3 | Opcode bits used when `op_i` is 0 |
| byte_i | input | 1 | 1 = byte operation, 0 = word |
| cin_en_i | input | 1 | 1 = carry-in from stored C flag |
| set_flags_i | input | 1 | Load the flag register this cycle |
| rshift_i | input | 1 | Shift the result right by one |
| zbus_o | output | 16 | Result bus |
| wb_o | output | 1 | Result is meant to be written back |
| flags_o | output | 4 | Stored flags {Z,N,V,C} |

## Verification
The embedded properties assume that all microword fields and operand buses are settled before each rising edge. They also assume that reset is held long enough for the flag register to start at zero. The properties tie the result bus to the ports only in configurations with no carry term, so they never depend on flag history.

The sweep changes inputs only on falling edges and runs the carry-dependent cases after flag loads, so every carry-in the bench predicts comes from its own model of the flag register. Directed vectors after the sweep cover the fault source, each constant code and the four idioms, starting from a known flag state.

// File: rtl/mcalu_pkg.sv
package mcalu_pkg;

   typedef enum logic [2:0] {FN_AND, FN_OR, FN_XOR, FN_ADD, FN_SUB} fn_e;
   typedef enum logic [1:0] {CI_ZERO, CI_ONE, CI_FLAG} ci_e;

   typedef struct packed {
      fn_e fn;
      ci_e ci;
      logic wb;
   } ctl_t;

   typedef struct packed {
      logic z;
      logic n;
      logic v;
      logic c;
   } flags_t;

   localparam logic [1:0] OPF_DEFER = 2'd0;
   localparam logic [1:0] OPF_AND   = 2'd1;
   localparam logic [1:0] OPF_SUB   = 2'd2;
   localparam logic [1:0] OPF_ADD   = 2'd3;

   // Microword function field plus opcode bits -> internal control
   function automatic ctl_t decode_fn(input logic [1:0] op,
                                      input logic [2:0] ir,
                                      input logic cin_en);
      ctl_t c;
      ci_e add_ci;
      ci_e sub_ci;
      add_ci = cin_en ? CI_FLAG : CI_ZERO;
      sub_ci = cin_en ? CI_FLAG : CI_ONE;
      c.wb = 1'b1;
      c.fn = FN_AND;
      c.ci = CI_ZERO;
      unique case (op)
         OPF_AND: c.fn = FN_AND;
         OPF_SUB: begin c.fn = FN_SUB; c.ci = sub_ci; end
         OPF_ADD: begin c.fn = FN_ADD; c.ci = add_ci; end
         default: begin
            unique case (ir)
               3'd0: begin c.fn = FN_SUB; c.ci = sub_ci; end
               3'd1: begin c.fn = FN_ADD; c.ci = add_ci; end
               3'd2: begin c.fn = FN_SUB; c.ci = sub_ci; c.wb = 1'b0; end
               3'd3: c.fn = FN_OR;
               3'd4: c.fn = FN_AND;
               3'd5: c.fn = FN_XOR;
               3'd6: begin c.fn = FN_ADD; c.ci = CI_FLAG; end
               default: begin c.fn = FN_SUB; c.ci = CI_FLAG; end
            endcase
         end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/mcalu_operand.sv
module mcalu_operand #(
   parameter int DATA_W = 16
) (
   input  logic [1:0]        rsel,
   input  logic [1:0]        imm,
   input  logic [DATA_W-1:0] mdr,
   input  logic [DATA_W-1:0] fault,
   output logic [DATA_W-1:0] rval
);

   localparam logic [DATA_W-1:0] K_ZERO = '0;
   localparam logic [DATA_W-1:0] K_ONE  = DATA_W'(1);
   localparam logic [DATA_W-1:0] K_MTWO = {{(DATA_W-1){1'b1}}, 1'b0};
   localparam logic [DATA_W-1:0] K_MONE = '1;

   if (DATA_W < 2) begin : g_bad_width
      $error("mcalu_operand: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] kval;

   always_comb begin
      unique case (imm)
         2'd0:    kval = K_ZERO;
         2'd1:    kval = K_ONE;
         2'd2:    kval = K_MTWO;
         default: kval = K_MONE;
      endcase
   end

   always_comb begin
      unique case (rsel)
         2'd0:    rval = mdr;
         2'd1:    rval = kval;
         2'd2:    rval = fault;
         default: rval = K_ZERO;
      endcase
   end

endmodule

// File: rtl/mcalu_compute.sv
module mcalu_compute
   import mcalu_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int NARROW_W    = 8,
   parameter bit SHIFT_ARITH = 1'b0
) (
   input  logic [DATA_W-1:0] lval,
   input  logic [DATA_W-1:0] rval,
   input  ctl_t              ctl,
   input  logic              byte_mode,
   input  logic              cflag,
   input  logic              shift,
   output logic [DATA_W-1:0] result,
   output flags_t            flags_nxt
);

   localparam int EXT_W = DATA_W - NARROW_W;

   if (NARROW_W < 1 || NARROW_W >= DATA_W) begin : g_bad_narrow
      $error("mcalu_compute: NARROW_W must lie between 1 and DATA_W-1");
   end

   logic                arith;
   logic                cin;
   logic [DATA_W-1:0]   rop;
   logic [DATA_W:0]     sum_w;
   logic [NARROW_W:0]   sum_n;
   logic [DATA_W-1:0]   logic_raw;
   logic [DATA_W-1:0]   raw;
   logic [DATA_W-1:0]   ext;
   logic                sl, sr, sres;

   assign arith = (ctl.fn == FN_ADD) || (ctl.fn == FN_SUB);
   assign rop   = (ctl.fn == FN_SUB) ? ~rval : rval;

   always_comb begin
      unique case (ctl.ci)
         CI_ONE:  cin = 1'b1;
         CI_FLAG: cin = cflag;
         default: cin = 1'b0;
      endcase
   end

   assign sum_w = {1'b0, lval} + {1'b0, rop} + {{DATA_W{1'b0}}, cin};
   assign sum_n = {1'b0, lval[NARROW_W-1:0]} + {1'b0, rop[NARROW_W-1:0]}
                + {{NARROW_W{1'b0}}, cin};

   always_comb begin
      unique case (ctl.fn)
         FN_OR:   logic_raw = lval | rval;
         FN_XOR:  logic_raw = lval ^ rval;
         default: logic_raw = lval & rval;
      endcase
   end

   always_comb begin
      if (arith) raw = byte_mode ? {{EXT_W{1'b0}}, sum_n[NARROW_W-1:0]} : sum_w[DATA_W-1:0];
      else       raw = logic_raw;
   end

   // Byte mode: upper part mirrors the narrow sign bit
   assign ext = byte_mode ? {{EXT_W{raw[NARROW_W-1]}}, raw[NARROW_W-1:0]} : raw;

   assign sl   = byte_mode ? lval[NARROW_W-1] : lval[DATA_W-1];
   assign sr   = byte_mode ? rop[NARROW_W-1]  : rop[DATA_W-1];
   assign sres = byte_mode ? raw[NARROW_W-1]  : raw[DATA_W-1];

   always_comb begin
      flags_nxt.z = byte_mode ? (raw[NARROW_W-1:0] == '0) : (raw == '0);
      flags_nxt.n = sres;
      flags_nxt.c = arith & (byte_mode ? sum_n[NARROW_W] : sum_w[DATA_W]);
      flags_nxt.v = arith & (sl == sr) & (sres != sl);
   end

   if (SHIFT_ARITH) begin : g_shift_arith
      assign result = shift ? {ext[DATA_W-1], ext[DATA_W-1:1]} : ext;
   end else begin : g_shift_logic
      assign result = shift ? {1'b0, ext[DATA_W-1:1]} : ext;
   end

endmodule

// File: rtl/mcalu_status.sv
module mcalu_status
   import mcalu_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load,
   input  flags_t nxt,
   output flags_t q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= nxt;
   end

   // R8: register keeps its value when no load is requested
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

   // R7: a load captures the flags offered in that cycle
   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(nxt)));

endmodule

// File: rtl/mcalu_unit.sv
module mcalu_unit
   import mcalu_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int NARROW_W    = 8,
   parameter bit SHIFT_ARITH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] lbus_i,
   input  logic [DATA_W-1:0] mdr_i,
   input  logic [DATA_W-1:0] fault_i,
   input  logic [1:0]        rsel_i,
   input  logic [1:0]        imm_i,
   input  logic [1:0]        op_i,
   input  logic [2:0]        ir_fn_i,
   input  logic              byte_i,
   input  logic              cin_en_i,
   input  logic              set_flags_i,
   input  logic              rshift_i,
   output logic [DATA_W-1:0] zbus_o,
   output logic              wb_o,
   output logic [3:0]        flags_o
);

   localparam int EXT_W = DATA_W - NARROW_W;

   if (NARROW_W >= DATA_W) begin : g_bad_cfg
      $error("mcalu_unit: narrow width must be below the word width");
   end

   logic [DATA_W-1:0] rval;
   ctl_t              ctl;
   flags_t            flags_nxt;
   flags_t            flags_q;

   assign ctl  = decode_fn(op_i, ir_fn_i, cin_en_i);
   assign wb_o = ctl.wb;

   mcalu_operand #(.DATA_W(DATA_W)) u_operand (
      .rsel  (rsel_i),
      .imm   (imm_i),
      .mdr   (mdr_i),
      .fault (fault_i),
      .rval  (rval)
   );

   mcalu_compute #(
      .DATA_W      (DATA_W),
      .NARROW_W    (NARROW_W),
      .SHIFT_ARITH (SHIFT_ARITH)
   ) u_compute (
      .lval      (lbus_i),
      .rval      (rval),
      .ctl       (ctl),
      .byte_mode (byte_i),
      .cflag     (flags_q.c),
      .shift     (rshift_i),
      .result    (zbus_o),
      .flags_nxt (flags_nxt)
   );

   mcalu_status u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (set_flags_i),
      .nxt   (flags_nxt),
      .q     (flags_q)
   );

   assign flags_o = flags_q;

   // R1 / R3: word AND with the memory data register reaches the bus intact
   p_and_mdr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsel_i == 2'd0 && op_i == OPF_AND && !byte_i && !rshift_i)
         |-> (zbus_o == (lbus_i & mdr_i)));

   // R5: byte results are sign extended on the bus
   p_signext_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_i && !rshift_i)
         |-> (zbus_o[DATA_W-1:NARROW_W] == {EXT_W{zbus_o[NARROW_W-1]}}));

   // R9: logical shift leaves the top bit clear
   p_shift_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rshift_i && !SHIFT_ARITH) |-> !zbus_o[DATA_W-1]);

   // R4: only the deferred compare suppresses writeback
   p_cmp_nowb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OPF_DEFER && ir_fn_i == 3'd2) |-> !wb_o);

   p_wb_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i != OPF_DEFER) |-> wb_o);

   // R10: increment idiom with no carry term
   p_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsel_i == 2'd1 && imm_i == 2'd1 && op_i == OPF_ADD && !cin_en_i
       && !byte_i && !rshift_i) |-> (zbus_o == lbus_i + DATA_W'(1)));

endmodule

// File: tb/mcalu_unit_bench.sv
module mcalu_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] lbus_i = '0, mdr_i = '0, fault_i = '0;
   logic [1:0]  rsel_i = '0, imm_i = '0, op_i = '0;
   logic [2:0]  ir_fn_i = '0;
   logic        byte_i = 0, cin_en_i = 0, set_flags_i = 0, rshift_i = 0;
   logic [15:0] zbus_o;
   logic        wb_o;
   logic [3:0]  flags_o;

   int checks = 0;
   int errors = 0;
   logic [3:0] mflags = 4'h0;
   logic       last_set = 1'b0;

   always #4 clk = ~clk;

   mcalu_unit u_mcalu_unit (
      .clk(clk), .rst_n(rst_n), .lbus_i(lbus_i), .mdr_i(mdr_i), .fault_i(fault_i),
      .rsel_i(rsel_i), .imm_i(imm_i), .op_i(op_i), .ir_fn_i(ir_fn_i),
      .byte_i(byte_i), .cin_en_i(cin_en_i), .set_flags_i(set_flags_i),
      .rshift_i(rshift_i), .zbus_o(zbus_o), .wb_o(wb_o), .flags_o(flags_o)
   );

   // Returns {wb, flags[3:0], bus[15:0]} computed from the requirements
   function automatic logic [20:0] model(input logic [15:0] l, input logic [15:0] r,
                                         input logic [1:0] op, input logic [2:0] ir,
                                         input logic bt, input logic ce, input logic sh,
                                         input logic [3:0] fl);
      int kind;  // 0 and, 1 or, 2 xor, 3 add, 4 sub
      int cin, n, mask, li, ri, s, res;
      logic wb, c, v, z, nf, sl, sr, sres;
      logic [15:0] ext, bus;
      wb = 1'b1; cin = 0; kind = 0;
      case (op)
         2'd1: kind = 0;
         2'd2: begin kind = 4; cin = ce ? int'(fl[0]) : 1; end
         2'd3: begin kind = 3; cin = ce ? int'(fl[0]) : 0; end
         default: case (ir)
            3'd0: begin kind = 4; cin = ce ? int'(fl[0]) : 1; end
            3'd1: begin kind = 3; cin = ce ? int'(fl[0]) : 0; end
            3'd2: begin kind = 4; cin = ce ? int'(fl[0]) : 1; wb = 1'b0; end
            3'd3: kind = 1;
            3'd4: kind = 0;
            3'd5: kind = 2;
            3'd6: begin kind = 3; cin = int'(fl[0]); end
            default: begin kind = 4; cin = int'(fl[0]); end
         endcase
      endcase
      n = bt ? 8 : 16;
      mask = (1 << n) - 1;
      li = int'(l) & mask;
      ri = int'(r) & mask;
      c = 1'b0; v = 1'b0;
      if (kind == 0)      res = li & ri;
      else if (kind == 1) res = li | ri;
      else if (kind == 2) res = li ^ ri;
      else begin
         if (kind == 4) ri = (~ri) & mask;
         s = li + ri + cin;
         res = s & mask;
         c = ((s >> n) & 1) != 0;
         sl = ((li >> (n-1)) & 1) != 0;
         sr = ((ri >> (n-1)) & 1) != 0;
         sres = ((res >> (n-1)) & 1) != 0;
         v = (sl == sr) && (sres != sl);
      end
      z = (res == 0);
      nf = ((res >> (n-1)) & 1) != 0;
      if (bt) ext = {{8{res[7]}}, res[7:0]};
      else    ext = res[15:0];
      bus = sh ? {1'b0, ext[15:1]} : ext;
      return {wb, z, nf, v, c, bus};
   endfunction

   function automatic logic [15:0] konst(input logic [1:0] k);
      case (k)
         2'd0: return 16'h0000;
         2'd1: return 16'h0001;
         2'd2: return 16'hFFFE;
         default: return 16'hFFFF;
      endcase
   endfunction

   task automatic check_flags();
      checks++;
      if (flags_o !== mflags) begin
         errors++;
         $display("FAIL %s flags: actual %h expected %h", last_set ? "R7" : "R8", flags_o, mflags);
      end
   endtask

   // One vector: called at a falling edge, checks the bus, advances one cycle
   task automatic run_vec(input string tag, input logic [15:0] l, input logic [15:0] m,
                          input logic [15:0] f, input logic [1:0] rs, input logic [1:0] im,
                          input logic [1:0] op, input logic [2:0] ir, input logic bt,
                          input logic ce, input logic sf, input logic sh);
      logic [15:0] rsrc;
      logic [20:0] e;
      check_flags();
      lbus_i = l; mdr_i = m; fault_i = f; rsel_i = rs; imm_i = im; op_i = op;
      ir_fn_i = ir; byte_i = bt; cin_en_i = ce; set_flags_i = sf; rshift_i = sh;
      case (rs)
         2'd0: rsrc = m;
         2'd1: rsrc = konst(im);
         2'd2: rsrc = f;
         default: rsrc = 16'h0000;
      endcase
      e = model(l, rsrc, op, ir, bt, ce, sh, mflags);
      #1;
      checks++;
      if (zbus_o !== e[15:0] || wb_o !== e[20]) begin
         errors++;
         $display("FAIL %s bus/wb: actual %h/%b expected %h/%b", tag, zbus_o, wb_o, e[15:0], e[20]);
      end
      if (sf) mflags = e[19:16];
      last_set = sf;
      @(negedge clk);
   endtask

   initial begin
      logic [15:0] lv [8];
      logic [15:0] rv [8];
      int cnt;
      string tag;
      lv = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h00FF, 16'h0080, 16'h1234};
      rv = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h007F, 16'h0080, 16'hFFFE, 16'hA5C3};
      cnt = 0;
      repeat (3) @(negedge clk);
      // R8: reset state of the flag register
      checks++;
      if (flags_o !== 4'h0) begin
         errors++;
         $display("FAIL R8 reset flags: actual %h expected 0", flags_o);
      end
      rst_n = 1'b1;
      @(negedge clk);

      for (int opi = 0; opi < 11; opi++)
         for (int rs = 0; rs < 4; rs++)
            for (int bt = 0; bt < 2; bt++)
               for (int ce = 0; ce < 2; ce++)
                  for (int sh = 0; sh < 2; sh++)
                     for (int li = 0; li < 8; li++)
                        for (int ri = 0; ri < 8; ri++) begin
                           logic [1:0] opv;
                           logic [2:0] irv;
                           opv = (opi < 3) ? 2'(opi + 1) : 2'd0;
                           // for direct codes the opcode bits carry noise (R3: ignored)
                           irv = (opi < 3) ? 3'(opi * 3 + ri) : 3'(opi - 3);
                           if (sh != 0)          tag = "R9";
                           else if (bt != 0)     tag = "R5";
                           else if (opv == 2'd0) tag = "R4";
                           else                  tag = "R3";
                           // R1 R2 R6 exercised across all sources, constants and carry modes
                           run_vec(tag, lv[li], rv[ri], ~rv[ri], 2'(rs), 2'(ri),
                                   opv, irv, bt[0], ce[0], (cnt % 3) != 1, sh[0]);
                           cnt++;
                        end

      // R8: flags hold across a cycle with loading off
      run_vec("R8", 16'h0000, 16'h0000, 16'h0, 2'd0, 2'd0, 2'd3, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
      run_vec("R8", 16'h8000, 16'h8000, 16'h0, 2'd0, 2'd0, 2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      // R1: fault-code source and the zero source
      run_vec("R1", 16'hFFFF, 16'h0F0F, 16'h3C3C, 2'd2, 2'd0, 2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      run_vec("R1", 16'hFFFF, 16'h0F0F, 16'h3C3C, 2'd3, 2'd3, 2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      // R2: each constant code through ADD
      for (int k = 0; k < 4; k++)
         run_vec("R2", 16'h1000, 16'h0, 16'h0, 2'd1, 2'(k), 2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      // R6: set C then add with carry enabled, then add-with-carry opcode
      run_vec("R6", 16'hFFFF, 16'h0001, 16'h0, 2'd0, 2'd0, 2'd3, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
      run_vec("R6", 16'h0001, 16'h0001, 16'h0, 2'd0, 2'd0, 2'd3, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
      run_vec("R6", 16'h0001, 16'h0001, 16'h0, 2'd0, 2'd0, 2'd0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0);
      run_vec("R6", 16'h0005, 16'h0001, 16'h0, 2'd0, 2'd0, 2'd0, 3'd7, 1'b0, 1'b0, 1'b1, 1'b0);
      // R10: increment, decrement, step by two, pass-through
      run_vec("R10", 16'h00FF, 16'h0, 16'h0, 2'd1, 2'd1, 2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      run_vec("R10", 16'h0100, 16'h0, 16'h0, 2'd1, 2'd3, 2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      run_vec("R10", 16'hFFFF, 16'h0, 16'h0, 2'd1, 2'd2, 2'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      run_vec("R10", 16'hBEEF, 16'h0, 16'h0, 2'd1, 2'd3, 2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      check_flags();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule